// File: doc/BRIEF.md
# Dual-Bank DRAM Access Sequencer

This block runs one 4-bit DRAM read or write at a time on one or two DRAM devices. The devices share the row strobe, write strobe, address and data lines, and each device has its own column strobe. A request is a strobe plus a read/write flag, a row address, a column address, a bank select and write data. The sequencer places every edge of the row strobe, the column strobes, the write strobe, the multiplexed address and the data-bus enable at a fixed count of system clocks from the request. It holds a busy flag for the whole access. For reads it latches the data bus when the column strobe rises and pulses a done flag.

A 2-bit geometry code selects the device arrangement: one or two devices, each 4M or 16M. With two small devices the top address pin becomes the second device's column strobe. With two large devices a separate strobe pin serves the second device, and all address pins carry address. An init strobe starts a burst of row-only refresh cycles for use at power-up. The block never issues any other refresh.

Top module: `dseq_top`

## Requirements
- R1: While reset is asserted and afterwards with no request, `busy`, `done` and `dq_oe` are 0 and `ras_n`, `cas_a_n`, `cas_c_n` and `we_n` are 1.
- R2: A request accepted while idle at clock edge E defines phases 0 to 8 as the nine clock periods after E. `ras_n` is low in phases 1 to 5 (5 clocks), so it is high for at least 3 clocks between accesses. The selected column strobe is low in phases 3 to 5 (3 clocks), so it falls 2 clocks after the row strobe and stays high for at least 5 clocks between pulses.
- R3: `addr` carries the row address in phases 0 and 1 and the column address in phases 2 to 8, apart from the top pin when R8 repurposes it. While idle the address bits are 0.
- R4: In a write, `we_n` is low and `dq_oe` is high with `dq_o` equal to the write data in phases 0 to 5 only. The write strobe therefore falls 3 clocks before the column strobe, and the data is held 3 clocks after the column strobe falls.
- R5: In a read, `we_n` stays high. `rdata` takes the value `dq_i` had in phase 5, which is the value at the column strobe's rising edge. `done` is high for exactly phase 6.
- R6: `busy` is high from the clock after acceptance through phase 8. A request seen while `busy` is high has no effect. A request held high starts the next access on the first clock that finds the sequencer idle.
- R7: The geometry code `cfg` maps as follows: 00 is two 16M devices, 10 is one 4M device, 01 is two 4M devices, 11 is one 16M device. With one device `bank` is ignored and `cas_a_n` pulses. With two devices `bank`=0 pulses `cas_a_n` and `bank`=1 pulses the second strobe. The strobe that is not selected stays high for the whole access.
- R8: With two 16M devices, `cas_c_n` is the second strobe and all 11 address bits carry address. With two 4M devices, `addr[10]` is the second strobe: high while idle and low only during a bank-1 pulse. With one 4M device `addr[10]` is 0. In every other code `cas_c_n` stays high.
- R9: `init` while idle runs 15 back-to-back row-only cycles (135 busy clocks). Each cycle uses the R2 row-strobe timing with the column strobes and `we_n` high, and cycle k drives row value k (0 to 14) on `addr`.
- R10: If `init` and `req` are both high on an idle clock, the refresh burst runs and the request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request strobe |
| wr | input | 1 | 1 = write, 0 = read |
| row | input | 11 | Row address |
| col | input | 11 | Column address |
| bank | input | 1 | Device select for two-device codes |
| wdata | input | 4 | Write data |
| cfg | input | 2 | Device geometry code |
| init | input | 1 | Start refresh burst |
| ras_n | output | 1 | Row strobe, shared |
| cas_a_n | output | 1 | Column strobe, first device |
| cas_c_n | output | 1 | Column strobe, second large device |
| we_n | output | 1 | Write strobe, shared |
| addr | output | 11 | Multiplexed address; top bit may be a strobe |
| dq_i | input | 4 | Data bus in |
| dq_o | output | 4 | Data bus out |
| dq_oe | output | 1 | Data bus drive enable |
| rdata | output | 4 | Latched read data |
| done | output | 1 | Read data valid pulse |
| busy | output | 1 | Sequence in progress |

## Verification
A wrong phase count shows on the strobe pins in the same clock: a row or column strobe edge that moves by one period, or a write window that misses the column strobe. A wrong geometry decode or a wrong bank latch shows as the wrong strobe pin pulsing, or as `addr[10]` dropping during a bank-0 pulse. A refresh counter that ends early or late shows as a busy period that differs from 135 clocks and as a wrong row value in a cycle. A reference model compares every pin on every clock, so each of these shows within one cycle of the first wrong edge.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

  typedef enum logic [1:0] {SQ_IDLE = 2'd0, SQ_ACC = 2'd1, SQ_REF = 2'd2} sq_mode_e;

  // Edge spacing in system clocks
  localparam int unsigned T_ROW_LEAD = 1;  // row valid before row strobe falls
  localparam int unsigned T_RAS_LOW  = 5;
  localparam int unsigned T_RAS_CAS  = 2;  // row strobe fall to column strobe fall
  localparam int unsigned T_CAS_LOW  = 3;
  localparam int unsigned T_RAS_PRE  = 3;
  localparam int unsigned T_WR_HOLD  = 3;  // data kept after column strobe falls

  localparam int unsigned N_RAS_ON  = T_ROW_LEAD;
  localparam int unsigned N_CAS_ON  = N_RAS_ON + T_RAS_CAS;
  localparam int unsigned N_CAS_OFF = N_CAS_ON + T_CAS_LOW;
  localparam int unsigned N_RAS_OFF = N_RAS_ON + T_RAS_LOW;
  localparam int unsigned N_WR_OFF  = N_CAS_ON + T_WR_HOLD;
  localparam int unsigned N_LAST    = N_RAS_OFF + T_RAS_PRE - 1;
  localparam int unsigned PH_W      = $clog2(N_LAST + 1);

  typedef logic [PH_W-1:0] phase_t;

  localparam phase_t P_RAS_ON  = phase_t'(N_RAS_ON);
  localparam phase_t P_RAS_OFF = phase_t'(N_RAS_OFF);
  localparam phase_t P_COL     = phase_t'(N_CAS_ON - 1);
  localparam phase_t P_CAS_ON  = phase_t'(N_CAS_ON);
  localparam phase_t P_CAS_OFF = phase_t'(N_CAS_OFF);
  localparam phase_t P_SAMPLE  = phase_t'(N_CAS_OFF - 1);
  localparam phase_t P_WR_OFF  = phase_t'(N_WR_OFF);
  localparam phase_t P_LAST    = phase_t'(N_LAST);

  typedef struct packed {
    logic dual;  // two devices fitted
    logic big;   // 16M devices
  } geom_t;

  function automatic geom_t decode_geom(input logic [1:0] code);
    geom_t g;
    g.dual = ~code[1];
    g.big  = (code[1] == code[0]);
    return g;
  endfunction

endpackage

// File: rtl/dseq_timer.sv
module dseq_timer
  import dseq_pkg::*;
#(
  parameter int unsigned REF_CYCLES = 15,
  localparam int unsigned REF_W = (REF_CYCLES > 1) ? $clog2(REF_CYCLES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             init,
  output sq_mode_e         mode,
  output phase_t           phase,
  output logic [REF_W-1:0] ref_idx,
  output logic             accept
);

  localparam logic [REF_W-1:0] REF_END = REF_W'(REF_CYCLES - 1);

  sq_mode_e         mode_q, mode_d;
  phase_t           ph_q, ph_d;
  logic [REF_W-1:0] ri_q, ri_d;

  always_comb begin
    mode_d = mode_q;
    ph_d   = ph_q;
    ri_d   = ri_q;
    accept = 1'b0;
    if (mode_q == SQ_IDLE) begin
      if (init) begin
        mode_d = SQ_REF;
        ph_d   = '0;
        ri_d   = '0;
      end else if (req) begin
        mode_d = SQ_ACC;
        ph_d   = '0;
        accept = 1'b1;
      end
    end else if (ph_q == P_LAST) begin
      if (mode_q == SQ_REF && ri_q != REF_END) begin
        ri_d = ri_q + 1'b1;
        ph_d = '0;
      end else begin
        mode_d = SQ_IDLE;
      end
    end else begin
      ph_d = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SQ_IDLE;
      ph_q   <= '0;
      ri_q   <= '0;
    end else begin
      mode_q <= mode_d;
      ph_q   <= ph_d;
      ri_q   <= ri_d;
    end
  end

  assign mode    = mode_q;
  assign phase   = ph_q;
  assign ref_idx = ri_q;

endmodule

// File: rtl/dseq_strobe.sv
module dseq_strobe
  import dseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 4,
  parameter int unsigned REF_W  = 4
) (
  input  sq_mode_e          mode,
  input  phase_t            phase,
  input  logic              wr,
  input  logic              bank,
  input  geom_t             geom,
  input  logic [ADDR_W-1:0] row,
  input  logic [ADDR_W-1:0] col,
  input  logic [REF_W-1:0]  ref_idx,
  input  logic [DATA_W-1:0] wdata,
  output logic              ras_n,
  output logic              cas_a_n,
  output logic              cas_c_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe
);

  logic ras_on, cas_on, wwin, sel2;
  logic [ADDR_W-1:0] amux;

  // The write window opens at phase 0: row lead plus row-to-column delay
  // equals the write lead, so it starts together with the access.
  always_comb begin
    ras_on = (mode != SQ_IDLE) && (phase >= P_RAS_ON) && (phase < P_RAS_OFF);
    cas_on = (mode == SQ_ACC) && (phase >= P_CAS_ON) && (phase < P_CAS_OFF);
    wwin   = (mode == SQ_ACC) && wr && (phase < P_WR_OFF);
    sel2   = geom.dual & bank;

    unique case (mode)
      SQ_REF:  amux = ADDR_W'(ref_idx);
      SQ_ACC:  amux = (phase < P_COL) ? row : col;
      default: amux = '0;
    endcase

    addr = amux;
    if (!geom.big) begin
      // top pin is a strobe for paired small parts, unused for a single one
      addr[ADDR_W-1] = geom.dual ? ~(cas_on & sel2) : 1'b0;
    end

    ras_n   = ~ras_on;
    cas_a_n = ~(cas_on & ~sel2);
    cas_c_n = ~(cas_on & sel2 & geom.big);
    we_n    = ~wwin;
    dq_oe   = wwin;
    dq_o    = wwin ? wdata : '0;
  end

endmodule

// File: rtl/dseq_top.sv
module dseq_top
  import dseq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 11,
  parameter int unsigned DATA_W     = 4,
  parameter int unsigned REF_CYCLES = 15,
  localparam int unsigned REF_W = (REF_CYCLES > 1) ? $clog2(REF_CYCLES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] row,
  input  logic [ADDR_W-1:0] col,
  input  logic              bank,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        cfg,
  input  logic              init,
  output logic              ras_n,
  output logic              cas_a_n,
  output logic              cas_c_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              busy
);

  // reset: asserted at once, released on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  sq_mode_e         mode;
  phase_t           phase;
  logic [REF_W-1:0] ref_idx;
  logic             accept;

  dseq_timer #(.REF_CYCLES(REF_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_i_n), .req(req), .init(init),
    .mode(mode), .phase(phase), .ref_idx(ref_idx), .accept(accept)
  );

  // request capture
  logic              wr_q, bank_q;
  logic [ADDR_W-1:0] row_q, col_q;
  logic [DATA_W-1:0] wd_q;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      wr_q   <= 1'b0;
      bank_q <= 1'b0;
      row_q  <= '0;
      col_q  <= '0;
      wd_q   <= '0;
    end else if (accept) begin
      wr_q   <= wr;
      bank_q <= bank;
      row_q  <= row;
      col_q  <= col;
      wd_q   <= wdata;
    end
  end

  dseq_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REF_W(REF_W)) u_strobe (
    .mode(mode), .phase(phase), .wr(wr_q), .bank(bank_q),
    .geom(decode_geom(cfg)), .row(row_q), .col(col_q), .ref_idx(ref_idx),
    .wdata(wd_q), .ras_n(ras_n), .cas_a_n(cas_a_n), .cas_c_n(cas_c_n),
    .we_n(we_n), .addr(addr), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  // read capture on the column strobe rising edge
  logic              cap;
  logic [DATA_W-1:0] rd_q;
  logic              dn_q;

  assign cap = (mode == SQ_ACC) && !wr_q && (phase == P_SAMPLE);

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rd_q <= '0;
      dn_q <= 1'b0;
    end else begin
      dn_q <= cap;
      if (cap) rd_q <= dq_i;
    end
  end

  assign rdata = rd_q;
  assign done  = dn_q;
  assign busy  = (mode != SQ_IDLE);

endmodule

// File: rtl/dseq_checker.sv
module dseq_checker #(
  parameter int unsigned ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_n,
  input logic              cas_a_n,
  input logic              cas_c_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        cfg,
  input logic              dq_oe,
  input logic              done,
  input logic              busy
);

  logic spare_cas;
  logic any_cas;
  assign spare_cas = (cfg == 2'b01) && !addr[ADDR_W-1];
  assign any_cas   = !cas_a_n || !cas_c_n || spare_cas;

  AST_RAS_LOW_FIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> ($past(ras_n, 2) == 1'b0 && $past(ras_n, 5) == 1'b0 && $past(ras_n, 6) == 1'b1)); // R2

  AST_CAS_AFTER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_a_n) || $fell(cas_c_n)) |-> ($past(ras_n, 2) == 1'b0 && $past(ras_n, 3) == 1'b1)); // R2

  AST_WE_LEADS_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> ##3 any_cas); // R4

  AST_WE_WITH_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (dq_oe && busy)); // R4

  AST_DONE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && we_n && ras_n)); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ras_n && cas_a_n && cas_c_n && we_n && !dq_oe)); // R6

  AST_ONE_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cas_a_n && (!cas_c_n || spare_cas))); // R7

  AST_THIRD_CAS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_c_n |-> (cfg == 2'b00)); // R8

endmodule

bind dseq_top dseq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_a_n(cas_a_n), .cas_c_n(cas_c_n),
  .we_n(we_n), .addr(addr), .cfg(cfg), .dq_oe(dq_oe), .done(done), .busy(busy)
);

// File: tb/tb_dseq_top.sv
`timescale 1ns/1ps
module tb_dseq_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, wr, bank, init;
  logic [10:0] row, col;
  logic [3:0]  wdata, dq_i;
  logic [1:0]  cfg;
  logic        ras_n, cas_a_n, cas_c_n, we_n, dq_oe, done, busy;
  logic [10:0] addr;
  logic [3:0]  dq_o, rdata;

  always #4 clk = ~clk;

  dseq_top dut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .row(row), .col(col),
    .bank(bank), .wdata(wdata), .cfg(cfg), .init(init), .ras_n(ras_n),
    .cas_a_n(cas_a_n), .cas_c_n(cas_c_n), .we_n(we_n), .addr(addr),
    .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe), .rdata(rdata), .done(done),
    .busy(busy)
  );

  int n_tot = 0;
  int n_fail = 0;
  bit fin = 1'b0;
  bit cmp_on = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: kind 0 idle, 1 access, 2 refresh
  int        m_kind = 0, m_t = 0, m_ridx = 0;
  bit        m_wr, m_bank;
  bit [10:0] m_row, m_col;
  bit [3:0]  m_wd, m_rdata = 0;
  int        ras_falls = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_kind = 0; m_t = 0; m_ridx = 0; m_rdata = 0;
    end else if (m_kind == 0) begin
      if (init) begin
        m_kind = 2; m_t = 0; m_ridx = 0;
      end else if (req) begin
        m_kind = 1; m_t = 0;
        m_wr = wr; m_bank = bank; m_row = row; m_col = col; m_wd = wdata;
      end
    end else begin
      if (m_kind == 1 && !m_wr && m_t == 5) m_rdata = dq_i;
      if (m_t == 8) begin
        if (m_kind == 2 && m_ridx < 14) begin m_ridx++; m_t = 0; end
        else m_kind = 0;
      end else m_t++;
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n && cmp_on) begin
      bit two, big, pulse, wwin;
      bit [10:0] ea;
      two   = !cfg[1];
      big   = (cfg[1] == cfg[0]);
      pulse = (m_kind == 1) && m_t >= 3 && m_t <= 5;
      wwin  = (m_kind == 1) && m_wr && m_t <= 5;
      if (m_kind == 0) ea = '0;
      else if (m_kind == 2) ea = 11'(m_ridx);
      else ea = (m_t <= 1) ? m_row : m_col;
      if (two && !big) ea[10] = !(pulse && m_bank);
      else if (!big) ea[10] = 1'b0;
      chk("R2 ras_n", ras_n, !((m_kind != 0) && m_t >= 1 && m_t <= 5));
      chk("R7 cas_a_n", cas_a_n, !(pulse && !(two && m_bank)));
      chk("R8 cas_c_n", cas_c_n, !(pulse && two && big && m_bank));
      chk("R3 addr", addr, ea);
      chk("R4 we_n", we_n, !wwin);
      chk("R4 dq_oe", dq_oe, wwin);
      if (wwin) chk("R4 dq_o", dq_o, m_wd);
      chk("R6 busy", busy, m_kind != 0);
      chk("R5 done", done, (m_kind == 1) && !m_wr && m_t == 6);
      chk("R5 rdata", rdata, m_rdata);
    end
  end

  always @(negedge clk) begin
    dq_i <= 4'($urandom);
  end

  always @(negedge ras_n) if (rst_n) ras_falls++;

  task automatic access(input bit w, input bit [10:0] r, input bit [10:0] c,
                        input bit b, input bit [3:0] d);
    @(negedge clk);
    req = 1'b1; wr = w; row = r; col = c; bank = b; wdata = d;
    @(negedge clk);
    req = 1'b0; row = ~r; col = ~c; wdata = ~d; bank = ~b; wr = ~w;
    repeat (9) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      n_tot++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = 0; wr = 0; bank = 0; init = 0;
    row = 0; col = 0; wdata = 0; cfg = 2'b11; dq_i = 0;
    repeat (4) @(negedge clk);
    // R1 during reset
    chk("R1 busy", busy, 0); chk("R1 ras_n", ras_n, 1); chk("R1 cas_a_n", cas_a_n, 1);
    chk("R1 cas_c_n", cas_c_n, 1); chk("R1 we_n", we_n, 1); chk("R1 dq_oe", dq_oe, 0);
    chk("R1 done", done, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after release", {busy, ras_n, we_n}, 3'b011);
    cmp_on = 1'b1;

    // R7 one 16M device: bank ignored
    cfg = 2'b11;
    access(1, 11'h5A3, 11'h2C7, 0, 4'hB);
    access(0, 11'h123, 11'h456, 1, 4'h0);
    // R8 two 16M devices
    cfg = 2'b00;
    access(1, 11'h7FF, 11'h400, 1, 4'h6);
    access(0, 11'h001, 11'h3FE, 1, 4'h0);
    access(0, 11'h555, 11'h2AA, 0, 4'h0);
    // R8 two 4M devices: addr[10] acts as strobe
    cfg = 2'b01;
    access(1, 11'h3A5, 11'h15A, 1, 4'h9);
    access(0, 11'h2F0, 11'h00F, 1, 4'h0);
    access(0, 11'h1E1, 11'h2D2, 0, 4'h0);
    // R8 one 4M device
    cfg = 2'b10;
    access(0, 11'h7C3, 11'h43C, 1, 4'h0);
    access(1, 11'h0F0, 11'h70F, 0, 4'h3);

    // R6 request during busy is ignored
    cfg = 2'b00;
    @(negedge clk); req = 1; wr = 0; row = 11'h111; col = 11'h222; bank = 0;
    @(negedge clk); req = 0;
    repeat (2) @(negedge clk);
    req = 1; wr = 1; row = 11'h333; col = 11'h444; bank = 1; wdata = 4'hF;
    @(negedge clk); req = 0;
    repeat (6) @(negedge clk);
    chk("R6 idle after ignored request", busy, 0);
    repeat (2) @(negedge clk);

    // R6 held request runs back to back
    req = 1; wr = 0; row = 11'h0AA; col = 11'h055; bank = 1;
    repeat (25) @(negedge clk);
    req = 0;
    repeat (10) @(negedge clk);

    // R9 / R10 refresh burst wins over a simultaneous request
    cfg = 2'b01;
    ras_falls = 0;
    init = 1; req = 1; wr = 1; row = 11'h7AB; col = 11'h0CD;
    @(negedge clk);
    init = 0; req = 0;
    chk("R10 refresh started", busy, 1);
    repeat (134) @(negedge clk);
    chk("R9 busy at last refresh clock", busy, 1);
    @(negedge clk);
    chk("R9 busy ends after 135", busy, 0);
    chk("R9 refresh count", ras_falls, 15);
    chk("R10 no write after refresh", we_n, 1);
    repeat (4) @(negedge clk);

    fin = 1'b1;
    summary();
    $finish;
  end

endmodule